// File: doc/BRIEF.md
# Serial Modulo-Ten Divisibility Checker

This block takes in an unsigned binary number one bit per clock, with the most significant bit first, and decides whether the number is a multiple of ten. It keeps only the running remainder of the bits seen so far. For each accepted bit, the remainder is doubled, the bit is added, and the result is reduced modulo ten. The next remainder comes from a small computed table, so the block needs no multiplier and no divider. Because only the remainder is stored, the block accepts operands of any length.

A producer raises a start strobe to begin a number. The bit that comes in the same cycle as the start strobe is the first bit of the new number. Bits are qualified by a valid strobe. An end marker closes the number. If the end marker comes with a valid bit, that bit is the last one. If it comes alone, the number ends with the bits already taken. One cycle after the end marker, the block raises a result pulse. The final remainder and the divisible flag are on the outputs in that same cycle.

The modulus is a parameter with a default of ten. The remainder width is derived from it.

Top module: `mod10_serial_checker`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs are remainder_o = 0, result_valid_o = 0 and divisible_o = 1, until the first start or valid cycle.
- R2: On a cycle with bit_valid_i = 1 and start_i = 0, remainder_o becomes (2·old remainder + bit_i) mod 10 on the next cycle.
- R3: On a cycle with start_i = 1, the old remainder is discarded. If bit_valid_i = 1 in that cycle, remainder_o becomes bit_i on the next cycle. Otherwise it becomes 0.
- R4: A cycle with start_i = 0 and bit_valid_i = 0 leaves remainder_o unchanged. This holds whatever value bit_i has.
- R5: result_valid_o is 1 in the cycle after a cycle with last_i = 1, and 0 after every other cycle. It lasts one cycle for each end marker.
- R6: divisible_o is 1 exactly when remainder_o is 0. While result_valid_o = 1, the pair shows the final remainder of the number and whether that number is a multiple of ten.
- R7: An end marker with no valid bit reports the remainder of the bits already taken. If start_i and last_i are both 1 with no valid bit, the result is remainder 0 and divisible.
- R8: A number hundreds of bits long gives the same remainder as its value mod 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Begins a new number and clears the remainder |
| bit_valid_i | input | 1 | Qualifies bit_i |
| bit_i | input | 1 | Serial operand bit, most significant first |
| last_i | input | 1 | End-of-number marker |
| remainder_o | output | 4 | Running remainder modulo ten |
| divisible_o | output | 1 | High when the remainder is zero |
| result_valid_o | output | 1 | One-cycle pulse carrying the final result |

## Verification
A wrong table entry or a lost bit shows up on remainder_o one cycle after the bit that caused it. The bench compares remainder_o against its model on every cycle, so the first bad cycle is seen at once and is not hidden until the end of a long number. A remainder that is not cleared by start, or that drifts on an idle cycle, gives a wrong value on remainder_o on the very next cycle. Errors in the result pulse or its pairing with the final remainder show up one cycle after each end marker. The stimulus includes empty numbers, single-bit numbers, restarts in the middle of a number and a 200-bit operand.

// File: rtl/mod10_chk_pkg.sv
package mod10_chk_pkg;
  // Remainder after appending one bit on the low end of a number.
  function automatic int append_bit(input int rem, input int b, input int modulus);
    return (2 * rem + b) % modulus;
  endfunction
endpackage

// File: rtl/mod10_chk_rst_sync.sv
module mod10_chk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mod10_chk_step.sv
module mod10_chk_step
  import mod10_chk_pkg::*;
#(
  parameter int MODULUS = 10,
  localparam int REM_W = $clog2(MODULUS),
  localparam int SLOTS = 1 << REM_W
) (
  input  logic [REM_W-1:0] rem_i,
  input  logic             bit_i,
  output logic [REM_W-1:0] rem_o
);
  logic [REM_W-1:0] tbl_zero [SLOTS];
  logic [REM_W-1:0] tbl_one  [SLOTS];

  for (genvar r = 0; r < SLOTS; r++) begin : g_tbl
    if (r < MODULUS) begin : g_live
      assign tbl_zero[r] = REM_W'(append_bit(r, 0, MODULUS));
      assign tbl_one[r]  = REM_W'(append_bit(r, 1, MODULUS));
    end else begin : g_dead
      assign tbl_zero[r] = '0;
      assign tbl_one[r]  = '0;
    end
  end

  assign rem_o = bit_i ? tbl_one[rem_i] : tbl_zero[rem_i];
endmodule

// File: rtl/mod10_chk_next.sv
module mod10_chk_next #(
  parameter int MODULUS = 10,
  localparam int REM_W = $clog2(MODULUS)
) (
  input  logic             start_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  input  logic [REM_W-1:0] rem_q_i,
  output logic             rem_en_o,
  output logic [REM_W-1:0] rem_d_o
);
  logic [REM_W-1:0] base;
  logic [REM_W-1:0] stepped;

  assign base = start_i ? '0 : rem_q_i;

  mod10_chk_step #(.MODULUS(MODULUS)) u_step (
    .rem_i (base),
    .bit_i (bit_i),
    .rem_o (stepped)
  );

  always_comb begin
    rem_en_o = start_i | bit_valid_i;
    rem_d_o  = bit_valid_i ? stepped : base;
  end
endmodule

// File: rtl/mod10_serial_checker.sv
module mod10_serial_checker #(
  parameter int MODULUS = 10,
  localparam int REM_W = $clog2(MODULUS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bit_valid_i,
  input  logic             bit_i,
  input  logic             last_i,
  output logic [REM_W-1:0] remainder_o,
  output logic             divisible_o,
  output logic             result_valid_o
);
  logic             rst_n_s;
  logic             rem_en;
  logic [REM_W-1:0] rem_d;
  logic [REM_W-1:0] rem_q;
  logic             rv_q;

  mod10_chk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  mod10_chk_next #(.MODULUS(MODULUS)) u_next (
    .start_i     (start_i),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .rem_q_i     (rem_q),
    .rem_en_o    (rem_en),
    .rem_d_o     (rem_d)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rv_q <= 1'b0;
    else          rv_q <= last_i;
  end

  assign remainder_o    = rem_q;
  assign divisible_o    = (rem_q == '0);
  assign result_valid_o = rv_q;

  // R2: remainder stays inside the residue range
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n_s)
    int'(remainder_o) < MODULUS);

  // R2: a plain bit doubles and adds
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bit_valid_i && !start_i) |=>
      int'(remainder_o) == (2 * int'($past(remainder_o)) + int'($past(bit_i))) % MODULUS);

  // R3: start discards the old remainder
  a_r3_start_clear: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && !bit_valid_i) |=> (remainder_o == '0));

  // R3: start with a bit folds that bit
  a_r3_start_bit: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start_i && bit_valid_i) |=> (int'(remainder_o) == int'($past(bit_i))));

  // R4: idle cycle holds
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!start_i && !bit_valid_i) |=> $stable(remainder_o));

  // R5: one pulse per end marker
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    last_i |=> result_valid_o);
  a_r5_no_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    !last_i |=> !result_valid_o);
endmodule

// File: tb/mod10_serial_checker_test.sv
`timescale 1ns/1ps
module mod10_serial_checker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, bit_valid_i, bit_i, last_i;
  logic [3:0] remainder_o;
  logic       divisible_o, result_valid_o;

  int checks = 0;
  int errors = 0;
  int exp_rem = 0;
  int exp_rv  = 0;

  always #5 clk = ~clk;

  mod10_serial_checker uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_valid_i(bit_valid_i),
    .bit_i(bit_i), .last_i(last_i), .remainder_o(remainder_o),
    .divisible_o(divisible_o), .result_valid_o(result_valid_o)
  );

  function automatic int model_next(int rem, bit st, bit vld, bit b);
    int base;
    base = st ? 0 : rem;
    if (vld) base = (2 * base + int'(b)) % 10;
    return base;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, clock it in, compare at the following negedge
  task automatic cyc(bit st, bit vld, bit b, bit lst, string tag);
    start_i = st; bit_valid_i = vld; bit_i = b; last_i = lst;
    exp_rem = model_next(exp_rem, st, vld, b);
    exp_rv  = int'(lst);
    @(posedge clk);
    @(negedge clk);
    check({tag, " R2 remainder"}, int'(remainder_o), exp_rem);
    check({tag, " R5 result_valid"}, int'(result_valid_o), exp_rv);
    check({tag, " R6 divisible"}, int'(divisible_o), int'(exp_rem == 0));
  endtask

  // send value v of n bits, MSB first, as one number
  task automatic send_word(longint unsigned v, int n, string tag);
    if (n == 0) begin
      cyc(1, 0, 0, 1, tag);
    end else begin
      for (int i = n - 1; i >= 0; i--)
        cyc(i == n - 1, 1, v[i], i == 0, tag);
    end
    check({tag, " R6 final mod10"}, int'(remainder_o), int'(v % 10));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start_i = 0; bit_valid_i = 0; bit_i = 0; last_i = 0;
    repeat (3) @(negedge clk);
    check("R1 reset remainder", int'(remainder_o), 0);
    check("R1 reset result_valid", int'(result_valid_o), 0);
    check("R1 reset divisible", int'(divisible_o), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 post-release remainder", int'(remainder_o), 0);

    send_word(64'd20, 5, "dir20");
    send_word(64'd7, 3, "dir7");
    send_word(64'd0, 0, "R7 empty");
    send_word(64'd1, 1, "R3 single");
    // R4 idle with toggling bit_i
    cyc(1, 1, 1, 0, "R3 fold");
    cyc(0, 1, 1, 0, "R2");
    cyc(0, 0, 1, 0, "R4 idle");
    cyc(0, 0, 0, 0, "R4 idle");
    check("R4 held remainder", int'(remainder_o), 3);
    cyc(0, 0, 0, 1, "R7 end alone");
    check("R7 end-alone final", int'(remainder_o), 3);
    // R3 restart mid-number
    cyc(1, 1, 1, 0, "R3 restart a");
    cyc(0, 1, 0, 0, "R3 restart b");
    cyc(1, 0, 0, 0, "R3 start no bit");
    check("R3 cleared", int'(remainder_o), 0);
    cyc(0, 0, 0, 1, "R7 start then end");

    // R8 long operand: 200 bits, value tracked mod 10 by bench
    begin
      int ref_mod = 0;
      for (int i = 0; i < 200; i++) begin
        bit b = 1'($urandom);
        ref_mod = (ref_mod * 2 + int'(b)) % 10;
        cyc(i == 0, 1, b, i == 199, "R8 long");
      end
      check("R8 long final", int'(remainder_o), ref_mod);
    end

    // random numbers with idle gaps
    for (int k = 0; k < 300; k++) begin
      int n = int'($urandom_range(0, 40));
      longint unsigned v = {$urandom, $urandom};
      if (n < 64) v = v & ((64'd1 << n) - 1);
      if (n == 0) cyc(1, 0, 0, 1, "rand empty");
      for (int i = n - 1; i >= 0; i--) begin
        if ($urandom_range(0, 3) == 0) cyc(0, 0, 1'($urandom), 0, "R4 rand idle");
        cyc(i == n - 1, 1, v[i], i == 0, "rand");
      end
      check("R6 rand final mod10", int'(remainder_o), int'(v % 10));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule